// File: doc/BRIEF.md
# Misaligned Operand Access Splitter

This block sits between a load/store unit and a data memory port with no wait states. It takes one operand request at a time: an address, a size code, a read/write flag and write data. It checks the address against natural alignment for the size. An aligned request goes to memory as one access. A misaligned request becomes a fixed series of smaller, naturally aligned bus accesses, issued one per cycle from the lowest address upward.

Data is big-endian, so the first piece carries the most significant bytes of the operand. Operands and bus pieces are right-justified: a byte sits in bits [7:0] and a word in bits [15:0]. On reads, the piece data is shifted into place and merged into one result. A one-cycle `done` pulse marks the end of every request. An output gives the number of bus accesses the request used beyond the first.

The request side is valid/ready. `req_ready` is high only while the block is idle. A request is taken on a rising edge where both `req_valid` and `req_ready` are high. While the block is busy, ready stays low and the request fields are ignored, so the producer must hold its request. The memory side has no back-pressure: every access completes in the cycle it is issued, and read data is sampled on that cycle's closing edge.

Top module: `opnd_split_unit`

## Requirements
- R1: Size codes are 0 = byte, 1 = word, 2 = long, and 3 is treated as long. A byte at any address, a word at an even address and a long at an address that is 0 modulo 4 each make exactly one bus access of the same size at the request address.
- R2: A word at an odd address makes two byte accesses, at A and then A+1. The byte at A is operand bits [15:8].
- R3: A long with address bits [1:0] = 10 makes two word accesses, at A and then A+2. The word at A is operand bits [31:16].
- R4: A long at an odd address makes three accesses: a byte at A, a word at A+1, then a byte at A+3. Every bus access is naturally aligned for its own size.
- R5: On a write, each piece carries the operand bytes it covers, in big-endian order and right-justified. The unused high bits of `mem_wdata` are zero.
- R6: On a read, `rsp_rdata` holds the whole operand, right-justified with zero upper bits, in the `done` cycle. After a write, `rsp_rdata` is zero in the `done` cycle.
- R7: Pieces occupy consecutive cycles, starting in the cycle after acceptance. With N pieces, `done` is high for exactly one cycle: N+1 cycles after acceptance for writes and aligned reads, and N+2 cycles after acceptance for misaligned reads. A misaligned read therefore costs N extra cycles and a misaligned write N-1.
- R8: `req_ready` is high exactly when no request is in progress, including the `done` cycle. Requests offered while busy are ignored, and the captured fields are used for the whole sequence.
- R9: From the cycle after acceptance until the next acceptance, `extra_ops` equals the number of bus accesses beyond the first for that request (0, 1 or 2). It is 0 after reset.
- R10: After reset the block is idle: `req_ready`=1, `mem_en`=0, `done`=0. `mem_en` is never high in a `done` cycle.
- R11: Piece addresses wrap modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | ADDR_W | Operand byte address |
| req_size | input | 2 | Size code: 0 byte, 1 word, 2 or 3 long |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write operand, right-justified |
| mem_en | output | 1 | Bus access this cycle |
| mem_we | output | 1 | Bus access is a write |
| mem_addr | output | ADDR_W | Bus access address |
| mem_size | output | 2 | Bus access size: 0 byte, 1 word, 2 long |
| mem_wdata | output | 32 | Piece write data, right-justified |
| mem_rdata | input | 32 | Piece read data, right-justified, same cycle |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Merged read operand, valid with done |
| extra_ops | output | 2 | Bus accesses beyond the first for the current request |

## Verification
The bench builds the block with ADDR_W = 8. At that width a full 256-byte memory model fits in the bench, so a long at 0xFF or 0xFD, or a word at 0xFF, splits into pieces that wrap to address 0. Every size code is tried at all four address offsets, for both reads and writes. The bench also sends back-to-back requests, and it holds a changing request on the port during a three-piece sequence.

// File: rtl/osu_pkg.sv
package osu_pkg;

  localparam int OSU_DW = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } osu_size_e;

  typedef struct packed {
    logic [1:0] off;    // byte offset from request address
    osu_size_e  psize;  // bus size of this piece
    logic [4:0] shift;  // bit position of piece LSB inside operand
  } osu_piece_t;

  // number of aligned bus pieces for a size / address-offset pair
  function automatic logic [1:0] osu_piece_count(osu_size_e s, logic [1:0] lsb);
    logic [1:0] n;
    case (s)
      SZ_BYTE: n = 2'd1;
      SZ_WORD: n = lsb[0] ? 2'd2 : 2'd1;
      default: begin
        if (lsb == 2'b00)  n = 2'd1;
        else if (lsb[0])   n = 2'd3;
        else               n = 2'd2;
      end
    endcase
    return n;
  endfunction

endpackage

// File: rtl/osu_plan.sv
module osu_plan
  import osu_pkg::*;
(
  input  osu_size_e  size_i,
  input  logic [1:0] lsb_i,
  input  logic [1:0] idx_i,
  output logic [1:0] count_o,
  output osu_piece_t piece_o
);

  osu_size_e norm;

  always_comb begin
    norm    = (size_i == SZ_RSVD) ? SZ_LONG : size_i;
    count_o = osu_piece_count(norm, lsb_i);
    piece_o = '{off: 2'd0, psize: norm, shift: 5'd0};
    if (norm == SZ_WORD && lsb_i[0]) begin
      // byte, byte
      if (idx_i == 2'd0) piece_o = '{off: 2'd0, psize: SZ_BYTE, shift: 5'd8};
      else               piece_o = '{off: 2'd1, psize: SZ_BYTE, shift: 5'd0};
    end else if (norm == SZ_LONG && lsb_i == 2'b10) begin
      // word, word
      if (idx_i == 2'd0) piece_o = '{off: 2'd0, psize: SZ_WORD, shift: 5'd16};
      else               piece_o = '{off: 2'd2, psize: SZ_WORD, shift: 5'd0};
    end else if (norm == SZ_LONG && lsb_i[0]) begin
      // byte, word, byte
      case (idx_i)
        2'd0:    piece_o = '{off: 2'd0, psize: SZ_BYTE, shift: 5'd24};
        2'd1:    piece_o = '{off: 2'd1, psize: SZ_WORD, shift: 5'd8};
        default: piece_o = '{off: 2'd3, psize: SZ_BYTE, shift: 5'd0};
      endcase
    end
  end

endmodule

// File: rtl/osu_lane.sv
module osu_lane
  import osu_pkg::*;
#(
  parameter int DW = OSU_DW
) (
  input  osu_size_e       psize_i,
  input  logic [4:0]      shift_i,
  input  logic [DW-1:0]   op_wdata_i,
  input  logic [DW-1:0]   bus_rdata_i,
  output logic [DW-1:0]   bus_wdata_o,
  output logic [DW-1:0]   op_field_o
);

  logic [DW-1:0] mask;

  always_comb begin
    case (psize_i)
      SZ_BYTE: mask = DW'(8'hFF);
      SZ_WORD: mask = DW'(16'hFFFF);
      default: mask = '1;
    endcase
    bus_wdata_o = (op_wdata_i >> shift_i) & mask;
    op_field_o  = (bus_rdata_i & mask) << shift_i;
  end

endmodule

// File: rtl/opnd_split_unit.sv
module opnd_split_unit
  import osu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [OSU_DW-1:0] req_wdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [OSU_DW-1:0] mem_wdata,
  input  logic [OSU_DW-1:0] mem_rdata,
  output logic              done,
  output logic [OSU_DW-1:0] rsp_rdata,
  output logic [1:0]        extra_ops
);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_ALIGN} st_e;

  st_e               st;
  logic [1:0]        idx;
  logic [ADDR_W-1:0] r_addr;
  osu_size_e         r_size;
  logic              r_we;
  logic [OSU_DW-1:0] r_wdata;
  logic [OSU_DW-1:0] acc;
  logic [OSU_DW-1:0] acc_next;
  logic              done_q;
  logic [OSU_DW-1:0] rsp_q;
  logic [1:0]        extra_q;

  logic [1:0]        cnt;
  osu_piece_t        piece;
  logic [OSU_DW-1:0] lane_wdata;
  logic [OSU_DW-1:0] lane_field;
  logic              accept;
  logic              last_piece;

  osu_plan u_plan (
    .size_i  (r_size),
    .lsb_i   (r_addr[1:0]),
    .idx_i   (idx),
    .count_o (cnt),
    .piece_o (piece)
  );

  osu_lane #(.DW(OSU_DW)) u_lane (
    .psize_i     (piece.psize),
    .shift_i     (piece.shift),
    .op_wdata_i  (r_wdata),
    .bus_rdata_i (mem_rdata),
    .bus_wdata_o (lane_wdata),
    .op_field_o  (lane_field)
  );

  assign req_ready  = (st == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign last_piece = (idx == cnt - 2'd1);
  assign acc_next   = ((idx == 2'd0) ? '0 : acc) | lane_field;

  assign mem_en    = (st == ST_ISSUE);
  assign mem_we    = mem_en && r_we;
  assign mem_addr  = r_addr + ADDR_W'(piece.off);
  assign mem_size  = piece.psize;
  assign mem_wdata = mem_we ? lane_wdata : '0;

  assign done      = done_q;
  assign rsp_rdata = rsp_q;
  assign extra_ops = extra_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      idx     <= '0;
      r_addr  <= '0;
      r_size  <= SZ_BYTE;
      r_we    <= 1'b0;
      r_wdata <= '0;
      acc     <= '0;
      done_q  <= 1'b0;
      rsp_q   <= '0;
      extra_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            st      <= ST_ISSUE;
            idx     <= '0;
            r_addr  <= req_addr;
            r_size  <= osu_size_e'(req_size);
            r_we    <= req_write;
            r_wdata <= req_wdata;
            extra_q <= osu_piece_count(osu_size_e'(req_size), req_addr[1:0]) - 2'd1;
          end
        end
        ST_ISSUE: begin
          if (!r_we) acc <= acc_next;
          idx <= idx + 2'd1;
          if (last_piece) begin
            if (!r_we && cnt != 2'd1) begin
              st <= ST_ALIGN;
            end else begin
              st     <= ST_IDLE;
              done_q <= 1'b1;
              rsp_q  <= r_we ? '0 : acc_next;
            end
          end
        end
        ST_ALIGN: begin
          st     <= ST_IDLE;
          done_q <= 1'b1;
          rsp_q  <= acc;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R7: the first piece follows acceptance directly
  a_r7_accept_issues: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> mem_en);

  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: no bus access in a done cycle
  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_en);

  // R8: nothing accepted while a piece is on the bus
  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> !req_ready);

  // R4: every word piece is even-addressed
  a_r4_word_piece_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_size == 2'd1) |-> !mem_addr[0]);

  // R4: every long piece is 0 modulo 4
  a_r4_long_piece_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_size == 2'd2) |-> (mem_addr[1:0] == 2'b00));

  // R9: extra count never exceeds two
  a_r9_extra_range: assert property (@(posedge clk) disable iff (!rst_n)
    extra_ops != 2'd3);

  // R11: consecutive pieces move to a new address
  a_r11_addr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en)) |-> (mem_addr != $past(mem_addr)));

endmodule

// File: tb/opnd_split_unit_test.sv
`timescale 1ns/1ps
module opnd_split_unit_test;

  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic          req_write = 1'b0;
  logic [31:0]   req_wdata = '0;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_size;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata;
  logic          done;
  logic [31:0]   rsp_rdata;
  logic [1:0]    extra_ops;

  always #2.5 clk = ~clk;  // 200 MHz

  opnd_split_unit #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .rsp_rdata(rsp_rdata), .extra_ops(extra_ops)
  );

  // zero-wait memory, big-endian, right-justified data
  logic [7:0] mem [0:255];
  logic [7:0] a1, a2, a3;
  assign a1 = mem_addr + 8'd1;
  assign a2 = mem_addr + 8'd2;
  assign a3 = mem_addr + 8'd3;

  always_comb begin
    case (mem_size)
      2'd0:    mem_rdata = {24'h0, mem[mem_addr]};
      2'd1:    mem_rdata = {16'h0, mem[mem_addr], mem[a1]};
      default: mem_rdata = {mem[mem_addr], mem[a1], mem[a2], mem[a3]};
    endcase
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37 + 11);
    end else if (mem_en && mem_we) begin
      case (mem_size)
        2'd0: mem[mem_addr] <= mem_wdata[7:0];
        2'd1: begin mem[mem_addr] <= mem_wdata[15:8]; mem[a1] <= mem_wdata[7:0]; end
        default: begin
          mem[mem_addr] <= mem_wdata[31:24]; mem[a1] <= mem_wdata[23:16];
          mem[a2] <= mem_wdata[15:8];        mem[a3] <= mem_wdata[7:0];
        end
      endcase
    end
  end

  // reference model: one queue entry per expected cycle
  typedef struct packed {
    logic        en;
    logic        we;
    logic [7:0]  addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic        dn;
    logic [31:0] rdata;
    logic [7:0]  tag;
  } exp_t;

  exp_t q[$];
  logic [1:0] exp_extra = 2'd0;
  int total = 0;
  int fails = 0;

  task automatic chk(input int tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // compare all outputs against the model for this cycle
  task automatic step();
    exp_t e;
    @(negedge clk);
    if (q.size() > 0) e = q.pop_front();
    else e = '{en: 1'b0, we: 1'b0, addr: 8'h0, size: 2'd0, wdata: 32'h0, dn: 1'b0, rdata: 32'h0, tag: 8'd10};
    chk(e.tag, "mem_en", 32'(mem_en), 32'(e.en));
    chk(7, "done", 32'(done), 32'(e.dn));               // R7 timing
    chk(8, "req_ready", 32'(req_ready), 32'(q.size() == 0)); // R8
    chk(9, "extra_ops", 32'(extra_ops), 32'(exp_extra)); // R9
    if (e.en) begin
      chk(e.tag, "mem_addr", 32'(mem_addr), 32'(e.addr));
      chk(e.tag, "mem_size", 32'(mem_size), 32'(e.size));
      chk(e.tag, "mem_we", 32'(mem_we), 32'(e.we));
      if (e.we) chk(5, "mem_wdata", mem_wdata, e.wdata); // R5
    end
    if (e.dn) chk(6, "rsp_rdata", rsp_rdata, e.rdata);   // R6
  endtask

  // build expected cycles from the requirements (R1-style rules per size)
  task automatic plan_req(input logic [7:0] a, input logic [1:0] sz, input logic we, input logic [31:0] wd);
    int nb, np, tag;
    int offs[3];
    int lens[3];
    logic [7:0] ob[4];
    logic [31:0] rv;
    exp_t e;
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    for (int i = 0; i < 4; i++) ob[i] = (i < nb) ? 8'(wd >> (8 * (nb - 1 - i))) : 8'h0;
    if (sz == 2'd1 && a[0]) begin                  // R2
      np = 2; offs = '{0, 1, 0}; lens = '{1, 1, 0}; tag = 2;
    end else if (nb == 4 && a[1:0] == 2'b10) begin // R3
      np = 2; offs = '{0, 2, 0}; lens = '{2, 2, 0}; tag = 3;
    end else if (nb == 4 && a[0]) begin            // R4
      np = 3; offs = '{0, 1, 3}; lens = '{1, 2, 1}; tag = 4;
    end else begin                                 // R1
      np = 1; offs = '{0, 0, 0}; lens = '{nb, 0, 0}; tag = 1;
    end
    if (int'(a) + nb > 256) tag = 11;              // R11 wrap
    for (int p = 0; p < np; p++) begin
      logic [31:0] v;
      v = 32'h0;
      for (int k = 0; k < lens[p]; k++) v = (v << 8) | 32'(ob[offs[p] + k]);
      e = '{en: 1'b1, we: we, addr: a + 8'(offs[p]),
            size: (lens[p] == 1) ? 2'd0 : (lens[p] == 2) ? 2'd1 : 2'd2,
            wdata: v, dn: 1'b0, rdata: 32'h0, tag: 8'(tag)};
      q.push_back(e);
    end
    if (np > 1 && !we)
      q.push_back('{en: 1'b0, we: 1'b0, addr: 8'h0, size: 2'd0, wdata: 32'h0, dn: 1'b0, rdata: 32'h0, tag: 8'd7});
    rv = 32'h0;
    if (!we) for (int k = 0; k < nb; k++) rv = (rv << 8) | 32'(mem[a + 8'(k)]);
    q.push_back('{en: 1'b0, we: 1'b0, addr: 8'h0, size: 2'd0, wdata: 32'h0, dn: 1'b1, rdata: rv, tag: 8'd7});
    exp_extra = 2'(np - 1);
  endtask

  task automatic issue(input logic [7:0] a, input logic [1:0] sz, input logic we, input logic [31:0] wd, input bit noise);
    while (!req_ready) step();
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = we; req_wdata = wd;
    plan_req(a, sz, we, wd);
    step();
    if (noise) begin
      // R8: changing request held while busy must be ignored
      req_addr = a + 8'h40; req_size = 2'd0; req_write = ~we; req_wdata = ~wd;
      while (q.size() > 0) step();
    end
    req_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();  // R10 reset state
    step();
    // R1..R4, R6: reads of every size at every offset
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 4; o++)
        issue(8'(8'h10 + o), 2'(s), 1'b0, 32'h0, 1'b0);
    // R5: writes of every size at every offset
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 4; o++)
        issue(8'(8'h40 + 8 * s + o), 2'(s), 1'b1, 32'hA1B2C3D4 ^ 32'(s * 16 + o), 1'b0);
    // R6: read back what was written, through misaligned pieces
    for (int s = 1; s < 3; s++)
      for (int o = 0; o < 4; o++)
        issue(8'(8'h40 + 8 * s + o), 2'(s), 1'b0, 32'h0, 1'b0);
    // R11: wrap at the top of the address space
    issue(8'hFF, 2'd2, 1'b0, 32'h0, 1'b0);
    issue(8'hFE, 2'd2, 1'b0, 32'h0, 1'b0);
    issue(8'hFD, 2'd2, 1'b0, 32'h0, 1'b0);
    issue(8'hFF, 2'd1, 1'b0, 32'h0, 1'b0);
    issue(8'hFF, 2'd2, 1'b1, 32'h5566_7788, 1'b0);
    issue(8'hFF, 2'd2, 1'b0, 32'h0, 1'b0);
    // R8: noise on the request port during busy sequences
    issue(8'h23, 2'd2, 1'b0, 32'h0, 1'b1);
    issue(8'h31, 2'd1, 1'b1, 32'hBEEF, 1'b1);
    issue(8'h30, 2'd1, 1'b0, 32'h0, 1'b1);
    while (q.size() > 0) step();
    repeat (3) step();  // R10 idle, R9 hold
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule